// File: doc/BRIEF.md
# Streaming Brightest-Spot Locator

This block sits beside the write path of a frame store. It looks at each intensity sample as the sample goes into memory, together with the sample's row and column address. The block keeps a three-sample horizontal window and the brightest accepted value of the frame in progress. Each frame yields one answer: the row and column of the brightest spot in that frame that looks like a laser, plus a flag that tells whether any such spot was found.

Frames rotate through a small set of capture banks. When a frame ends, its answer is stored in a slot tagged with that frame's bank number. The analysis of the next frame then starts from a clean state. A separate readout bank number chooses which stored answer appears on the outputs, so a display or controller can read a finished frame while the next one is being analysed.

Samples enter through a valid/ready handshake. The block can take a sample on every clock, so `in_ready` is always high and there is never back-pressure. A sample counts only on a cycle where `in_valid` is high. Cycles without a sample have no effect on the window or on the analysis state.

Top module: `spot_tracker`

## Requirements
- R1: A sample becomes a candidate only when it, the sample before it and the sample after it in the same row are all strictly greater than 250 (the default threshold). A value of exactly 250 anywhere in the window rejects it.
- R2: A candidate replaces the frame's current best only when its value is strictly greater than the best value accepted so far in that frame. An equal value keeps the earlier location. A larger value later in the frame takes over.
- R3: When a candidate is accepted, the frame's answer becomes: found flag 1, the current row, and the current column minus one (the column of the middle sample).
- R4: A frame starts on any accepted sample that has row 0 and column 0, or whose capture bank differs from the bank of the previous accepted sample. A frame start clears the running location, found flag and best value. It also empties the window, and the start sample becomes its only entry.
- R5: A sample in column 0 empties the window and becomes its only entry, so no window crosses a row boundary. Columns 0 and 255 are therefore never reported. Columns 1 and 254 can be reported.
- R6: On a cycle where `in_valid` is low, the window and analysis state do not change, so idle gaps inside a row do not break a window. `in_ready` is always 1.
- R7: At each frame start, the answer of the frame that just ended is stored in the slot numbered by that frame's capture bank. The outputs show the slot chosen by `rd_bank`, combinationally, as soon as the storing clock edge has passed. Other slots keep their contents.
- R8: After reset every slot holds found 0, row 0 and column 0, and the capture bank of the "previous" sample is taken to be 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A sample is offered this cycle |
| in_ready | output | 1 | Always 1; the block takes every offered sample |
| in_row | input | 8 | Row address of the sample |
| in_col | input | 8 | Column address of the sample |
| in_pix | input | 8 | Intensity of the sample |
| cap_bank | input | 2 | Bank the sample's frame is written to |
| rd_bank | input | 2 | Slot chosen for the outputs |
| spot_found | output | 1 | The chosen slot's frame contained a spot |
| spot_row | output | 8 | Row of the chosen slot's spot |
| spot_col | output | 8 | Column of the chosen slot's spot |

## Verification
A frame's answer is stored on the clock edge that accepts the first sample of the next frame. After that edge the outputs follow `rd_bank` with no further delay. The bench therefore checks a slot only after that start sample has been taken, driving `rd_bank` on a falling edge and sampling one nanosecond later. Window and best-value updates happen on the edge that takes each sample. Their effect is observed only through stored answers and never read from inside the design. The expected slot contents come from a bench model that applies the requirements sample by sample as each edge passes.

// File: rtl/spot_pkg.sv
package spot_pkg;

  // What the window does with the sample on the current cycle.
  typedef enum logic [1:0] {
    WIN_HOLD    = 2'd0,   // no sample this cycle
    WIN_RESTART = 2'd1,   // frame or row start: window emptied, sample loaded
    WIN_SHIFT   = 2'd2    // ordinary sample: shift history
  } win_op_t;

  localparam int DEF_PIX_W  = 8;
  localparam int DEF_ADDR_W = 8;
  localparam int DEF_BANK_W = 2;
  localparam int DEF_THRESH = 250;

endpackage

// File: rtl/spot_window.sv
module spot_window
  import spot_pkg::*;
#(
  parameter int PIX_W  = DEF_PIX_W,
  parameter int THRESH = DEF_THRESH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  win_op_t          op,
  input  logic [PIX_W-1:0] pix,
  input  logic [PIX_W-1:0] best_val,
  output logic             hit,
  output logic [PIX_W-1:0] mid
);

  localparam int TAPS = 3;
  localparam logic [PIX_W-1:0] THR = PIX_W'(THRESH);

  logic [PIX_W-1:0] h0_q, h1_q;
  logic [PIX_W-1:0] taps [TAPS];
  logic [TAPS-1:0]  over;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h0_q <= '0;
      h1_q <= '0;
    end else begin
      case (op)
        WIN_RESTART: begin
          h0_q <= pix;
          h1_q <= '0;
        end
        WIN_SHIFT: begin
          h0_q <= pix;
          h1_q <= h0_q;
        end
        default: ;
      endcase
    end
  end

  assign taps[0] = pix;
  assign taps[1] = h0_q;
  assign taps[2] = h1_q;

  for (genvar t = 0; t < TAPS; t++) begin : g_thr
    assign over[t] = taps[t] > THR;
  end

  assign mid = h0_q;
  assign hit = (op == WIN_SHIFT) && (&over) && (h0_q > best_val);

  AST_WIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == WIN_HOLD) |=> ($stable(h0_q) && $stable(h1_q))); // R6

  AST_WIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (op == WIN_RESTART) |=> (h1_q == '0)); // R5

endmodule

// File: rtl/spot_frame_ctl.sv
module spot_frame_ctl
  import spot_pkg::*;
#(
  parameter int PIX_W  = DEF_PIX_W,
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int BANK_W = DEF_BANK_W,
  parameter int THRESH = DEF_THRESH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [ADDR_W-1:0] row,
  input  logic [ADDR_W-1:0] col,
  input  logic [BANK_W-1:0] bank,
  input  logic              hit,
  input  logic [PIX_W-1:0]  mid,
  output win_op_t           op,
  output logic [PIX_W-1:0]  best_val,
  output logic              done,
  output logic [BANK_W-1:0] done_bank,
  output logic              done_found,
  output logic [ADDR_W-1:0] done_row,
  output logic [ADDR_W-1:0] done_col
);

  localparam logic [ADDR_W-1:0] COL_LAST = '1;
  localparam logic [PIX_W-1:0]  THR      = PIX_W'(THRESH);

  logic [BANK_W-1:0] last_bank_q;
  logic              found_q;
  logic [ADDR_W-1:0] row_q, col_q;
  logic [PIX_W-1:0]  max_q;
  logic              origin, frame_start, row_start;

  assign origin      = (row == '0) && (col == '0);
  assign frame_start = valid && (origin || (bank != last_bank_q));
  assign row_start   = valid && (col == '0);

  always_comb begin
    if (!valid)                       op = WIN_HOLD;
    else if (frame_start || row_start) op = WIN_RESTART;
    else                              op = WIN_SHIFT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_bank_q <= '0;
      found_q     <= 1'b0;
      row_q       <= '0;
      col_q       <= '0;
      max_q       <= '0;
    end else if (valid) begin
      last_bank_q <= bank;
      if (frame_start) begin
        found_q <= 1'b0;
        row_q   <= '0;
        col_q   <= '0;
        max_q   <= '0;
      end else if (hit) begin
        found_q <= 1'b1;
        row_q   <= row;
        col_q   <= col - 1'b1;
        max_q   <= mid;
      end
    end
  end

  assign best_val   = max_q;
  assign done       = frame_start;
  assign done_bank  = last_bank_q;
  assign done_found = found_q;
  assign done_row   = row_q;
  assign done_col   = col_q;

  AST_FRAME_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!found_q && (max_q == '0))); // R4

  AST_MAX_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !frame_start) |=> (max_q >= $past(max_q))); // R2

  AST_EDGE_COLS: assert property (@(posedge clk) disable iff (!rst_n)
    found_q |-> ((col_q != '0) && (col_q != COL_LAST))); // R5

  AST_FOUND_BRIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    found_q |-> (max_q > THR)); // R1

endmodule

// File: rtl/spot_result_bank.sv
module spot_result_bank
  import spot_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int BANK_W = DEF_BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BANK_W-1:0] wbank,
  input  logic              w_found,
  input  logic [ADDR_W-1:0] w_row,
  input  logic [ADDR_W-1:0] w_col,
  input  logic [BANK_W-1:0] rbank,
  output logic              r_found,
  output logic [ADDR_W-1:0] r_row,
  output logic [ADDR_W-1:0] r_col
);

  localparam int SLOTS = 2 ** BANK_W;
  localparam int REC_W = 1 + 2 * ADDR_W;

  logic [REC_W-1:0] wdata;
  logic [REC_W-1:0] slot_q [SLOTS];

  assign wdata = {w_found, w_row, w_col};

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[s] <= '0;
      else if (we && (wbank == BANK_W'(s)))
        slot_q[s] <= wdata;
    end
  end

  assign {r_found, r_row, r_col} = slot_q[rbank];

  AST_SLOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (slot_q[$past(wbank)] == $past(wdata))); // R7

endmodule

// File: rtl/spot_tracker.sv
module spot_tracker
  import spot_pkg::*;
#(
  parameter int PIX_W  = DEF_PIX_W,
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int BANK_W = DEF_BANK_W,
  parameter int THRESH = DEF_THRESH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_row,
  input  logic [ADDR_W-1:0] in_col,
  input  logic [PIX_W-1:0]  in_pix,
  input  logic [BANK_W-1:0] cap_bank,
  input  logic [BANK_W-1:0] rd_bank,
  output logic              spot_found,
  output logic [ADDR_W-1:0] spot_row,
  output logic [ADDR_W-1:0] spot_col
);

  win_op_t           op;
  logic              hit;
  logic [PIX_W-1:0]  mid, best_val;
  logic              done, done_found;
  logic [BANK_W-1:0] done_bank;
  logic [ADDR_W-1:0] done_row, done_col;
  logic              take;

  assign in_ready = 1'b1;
  assign take     = in_valid && in_ready;

  spot_window #(.PIX_W(PIX_W), .THRESH(THRESH)) u_win (
    .clk(clk), .rst_n(rst_n), .op(op), .pix(in_pix),
    .best_val(best_val), .hit(hit), .mid(mid)
  );

  spot_frame_ctl #(.PIX_W(PIX_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W),
                   .THRESH(THRESH)) u_ctl (
    .clk(clk), .rst_n(rst_n), .valid(take), .row(in_row), .col(in_col),
    .bank(cap_bank), .hit(hit), .mid(mid), .op(op), .best_val(best_val),
    .done(done), .done_bank(done_bank), .done_found(done_found),
    .done_row(done_row), .done_col(done_col)
  );

  spot_result_bank #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_res (
    .clk(clk), .rst_n(rst_n), .we(done), .wbank(done_bank),
    .w_found(done_found), .w_row(done_row), .w_col(done_col),
    .rbank(rd_bank), .r_found(spot_found), .r_row(spot_row), .r_col(spot_col)
  );

endmodule

// File: tb/tb_spot_tracker.sv
`timescale 1ns/1ps
module tb_spot_tracker;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_row = '0, in_col = '0, in_pix = '0;
  logic [1:0] cap_bank = '0, rd_bank = '0;
  logic       spot_found;
  logic [7:0] spot_row, spot_col;

  int checks = 0, fails = 0;
  bit done_flag = 0;

  // bench reference state
  int mh0 = 0, mh1 = 0, mmax = 0, mrow = 0, mcol = 0, mfound = 0, mlast = 0;
  int ef[4], er[4], ec[4];

  always #2.5 clk = ~clk;

  spot_tracker dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_row(in_row), .in_col(in_col), .in_pix(in_pix), .cap_bank(cap_bank),
    .rd_bank(rd_bank), .spot_found(spot_found), .spot_row(spot_row),
    .spot_col(spot_col)
  );

  function automatic void model_step(int r, int c, int p, int b);
    if ((r == 0 && c == 0) || b != mlast) begin
      ef[mlast] = mfound; er[mlast] = mrow; ec[mlast] = mcol;
      mfound = 0; mrow = 0; mcol = 0; mmax = 0;
      mh0 = p; mh1 = 0;
    end else if (c == 0) begin
      mh0 = p; mh1 = 0;
    end else begin
      if (mh0 > 250 && mh1 > 250 && p > 250 && mh0 > mmax) begin
        mfound = 1; mrow = r; mcol = c - 1; mmax = mh0;
      end
      mh1 = mh0; mh0 = p;
    end
    mlast = b;
  endfunction

  task automatic send(int r, int c, int p, int b);
    @(negedge clk);
    in_valid = 1'b1; in_row = r[7:0]; in_col = c[7:0];
    in_pix = p[7:0]; cap_bank = b[1:0];
    @(posedge clk);
    model_step(r, c, p, b);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_pix = 8'($urandom); in_col = 8'($urandom);
      in_row = 8'($urandom);
    end
  endtask

  task automatic check_slot(int b, string req);
    @(negedge clk);
    in_valid = 1'b0; rd_bank = b[1:0];
    #1;
    checks++;
    if (spot_found !== ef[b][0] || spot_row !== er[b][7:0] ||
        spot_col !== ec[b][7:0]) begin
      fails++;
      $display("FAIL %s slot %0d: got found=%0d row=%0d col=%0d, expected found=%0d row=%0d col=%0d",
               req, b, spot_found, spot_row, spot_col, ef[b], er[b], ec[b]);
    end
  endtask

  task automatic send_row(int r, int b, int vals[], int width);
    for (int c = 0; c < width; c++)
      send(r, c, (c < vals.size()) ? vals[c] : 0, b);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done_flag) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int b = 0; b < 4; b++) begin ef[b] = 0; er[b] = 0; ec[b] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset contents of every slot
    for (int b = 0; b < 4; b++) check_slot(b, "R8");

    // R6: no back-pressure
    checks++;
    if (in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R6 in_ready: got %0d expected 1", in_ready);
    end

    // Frame in bank 1: R1 threshold, R2 equal does not replace, R3 location
    send(0, 0, 10, 1);
    send_row(3, 1, '{0, 0, 0, 251, 252, 251}, 10);
    send_row(4, 1, '{0, 251, 252, 251}, 10);
    send_row(5, 1, '{0, 251, 255, 250}, 10);
    send_row(6, 1, '{0, 0, 0, 0, 0, 0, 251, 251, 251}, 10);
    send(0, 0, 0, 2);            // R7: bank change ends the frame
    check_slot(1, "R1 R2 R3 R7");

    // Frame in bank 2: larger value takes over (R2), restart at origin (R4)
    send_row(1, 2, '{0, 251, 253, 251}, 6);
    send_row(2, 2, '{0, 251, 254, 251}, 6);
    send(0, 0, 0, 2);            // R4: origin with same bank ends frame
    check_slot(2, "R2 R4");
    send(0, 0, 0, 3);            // empty frame in bank 2
    check_slot(2, "R4 clear");
    check_slot(1, "R7 other slot kept");

    // Bank 3: window must not span rows (R5)
    for (int c = 0; c < 256; c++) send(7, c, (c >= 254) ? 255 : 0, 3);
    send(8, 0, 255, 3);
    send(8, 1, 0, 3);
    send(0, 0, 0, 0);
    check_slot(3, "R5 row wrap");

    // Bank 0: columns 1 and 254 reportable (R5)
    send_row(9, 0, '{251, 251, 251}, 4);
    for (int c = 0; c < 256; c++)
      send(10, c, (c == 253) ? 252 : (c == 254) ? 253 : (c == 255) ? 254 : 0, 0);
    send(0, 0, 0, 1);
    check_slot(0, "R5 edge columns");

    // Bank 1: idle gaps do not break the window (R6)
    send(2, 0, 0, 1);
    send(2, 1, 251, 1);
    idle(3);
    send(2, 2, 253, 1);
    idle(2);
    send(2, 3, 251, 1);
    send(2, 4, 0, 1);
    send(0, 0, 0, 2);
    check_slot(1, "R6 idle gaps");

    // Random frames
    for (int f = 0; f < 40; f++) begin
      int prev, nb, rows;
      prev = mlast;
      nb = int'($urandom % 4);
      if ($urandom % 2) send(0, 0, int'($urandom % 256), nb);
      else begin
        if (nb == prev) nb = (nb + 1) % 4;
        send(1 + int'($urandom % 100), 0, int'($urandom % 256), nb);
      end
      check_slot(prev, "R3 R4 R7 random");
      rows = 1 + int'($urandom % 4);
      for (int r = 0; r < rows; r++) begin
        int w, rr;
        w = 3 + int'($urandom % 14);
        rr = 1 + int'($urandom % 200);
        for (int c = 0; c < w; c++) begin
          int p;
          p = ($urandom % 3 != 0) ? 246 + int'($urandom % 10) : int'($urandom % 256);
          send(rr, c, p, nb);
          if ($urandom % 8 == 0) idle(1 + int'($urandom % 3));
        end
      end
      if (f % 8 == 7)
        for (int b = 0; b < 4; b++) check_slot(b, "R1 R2 R7 sweep");
    end
    send(0, 0, 0, (mlast + 1) % 4);
    for (int b = 0; b < 4; b++) check_slot(b, "R7 final");

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule